// File: doc/BRIEF.md
# SPI Framed Register Access Slave

This block is an SPI slave (mode 0) that lets an external host reach registers and buffer memories inside the chip. Every transaction is a frame with three parts in a fixed order. First comes a 16-bit offset, high byte first. Next is one control byte. The control byte names a target block, a direction and a length mode. Data bytes follow the control byte. The slave turns each complete data byte into a single-cycle write or read strobe on a plain internal port. That port carries an offset, a block select and write data. Read data goes back to the host on MISO.

The host can end a frame in one of two ways. In variable mode, the host ends the frame by deasserting chip select. In fixed mode, the slave stops after 1, 2 or 4 bytes and ignores any later clocks. The slave moves the offset up by one after each data byte, so a multi-byte access covers consecutive locations.

The SPI pins are sampled with the system clock through synchronizers. For this reason, each SCLK half-period must last at least SYNC_STAGES + 2 system clock cycles.

Top module: `spi_frame_slave`

## Requirements
- R1: Out of reset, and whenever chip select is high, `bus_wr` and `bus_rd` stay low and `spi_miso` is driven low.
- R2: After chip select falls, the slave takes bits on rising SCLK edges, MSB first. The first byte is offset[15:8] and the second is offset[7:0]. The third byte is the control byte: bits [7:3] are the block select, bit 2 is the direction (1 = write, 0 = read), and bits [1:0] are the mode (00 variable, 01 fixed 1, 10 fixed 2, 11 fixed 4).
- R3: In a write frame, each complete data byte produces exactly one `bus_wr` pulse that is one clock wide. During that pulse, `bus_wdata` holds the byte, and `bus_addr` and `bus_blk` hold the current offset and block.
- R4: The offset increases by one (modulo 2^16) after every data byte, so data byte k of a frame starting at offset A goes to offset A+k.
- R5: In a fixed mode, the slave accesses at most 1, 2 or 4 bytes (mode 01, 10, 11). Bytes clocked after that count cause no strobe and return 0 on MISO.
- R6: In variable mode, every complete data byte is accessed until chip select rises. A read frame of N bytes issues N+1 `bus_rd` strobes, because the slave always prefetches the next byte.
- R7: In a read frame, the slave fetches the byte at the frame offset right after the control byte. It fetches each later byte right after the previous one completes. Each byte is shifted out on MISO MSB first, changing after falling SCLK edges, so it is valid at the rising edges of the byte that follows.
- R8: If chip select rises in the middle of a byte, the partial byte causes no strobe. This holds in any phase.
- R9: A falling chip select always restarts decoding at the offset high byte, even after an aborted frame.
- R10: `bus_wr` and `bus_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_addr | output | 16 | Offset of the current access |
| bus_blk | output | 5 | Block select of the current access |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_wdata | output | 8 | Write data, valid with `bus_wr` |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid in the cycle after `bus_rd` |

## Verification
The bench sweeps every length mode in both directions over one to five data bytes. It starts one frame of each kind at offset 0xFFFE, so the offset must wrap.

Each of the following faults shows up in the sweep:
- A slave that miscounts fixed lengths shows extra or missing strobes, or it returns nonzero bytes after the count.
- A slave that increments the offset at the wrong time puts the first read or write one location off.
- A slave that does not prefetch puts stale data on MISO.

The abort cases raise chip select in the middle of a data byte and in the middle of the address. A slave that kept the partial byte would issue a stray strobe. A slave that did not restart on the next chip-select fall would decode that next frame's address from the wrong byte.

// File: rtl/spi_frame_slave.sv
module spi_frame_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [15:0] bus_addr,
  output logic [4:0]  bus_blk,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  output logic        bus_rd,
  input  logic [7:0]  bus_rdata
);
  localparam int AW = 16;
  localparam int BW = 5;
  localparam int DW = 8;
  localparam int TOP = SYNC_STAGES - 1;

  typedef enum logic [1:0] {PH_ADDR, PH_CTRL, PH_DATA, PH_DONE} phase_t;

  logic [TOP:0] sclk_sy, cs_sy, mosi_sy;
  logic         sclk_d;
  phase_t       phase;
  logic [2:0]   bit_cnt;
  logic         hi_done;
  logic [DW-1:0] sh_in, wdata_q, txbuf, tx_sh;
  logic [AW-1:0] addr;
  logic [BW-1:0] blk;
  logic          is_wr, fixed, wr_q, rd_q, cap_q;
  logic [2:0]    left;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[TOP-1:0], spi_sclk};
      cs_sy   <= {cs_sy[TOP-1:0], spi_cs_n};
      mosi_sy <= {mosi_sy[TOP-1:0], spi_mosi};
      sclk_d  <= sclk_sy[TOP];
    end

  wire          cs_hi    = cs_sy[TOP];
  wire          rise     = sclk_sy[TOP] & ~sclk_d;
  wire          fall     = ~sclk_sy[TOP] & sclk_d;
  wire [DW-1:0] byte_in  = {sh_in[DW-2:0], mosi_sy[TOP]};
  wire          last_bit = rise && bit_cnt == 3'd7;
  wire          more     = !fixed || left != 3'd1;
  wire [2:0]    len      = byte_in[1:0] == 2'b01 ? 3'd1 :
                           byte_in[1:0] == 2'b10 ? 3'd2 :
                           byte_in[1:0] == 2'b11 ? 3'd4 : 3'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      hi_done <= 1'b0;
      sh_in   <= '0;
      wdata_q <= '0;
      txbuf   <= '0;
      tx_sh   <= '0;
      addr    <= '0;
      blk     <= '0;
      is_wr   <= 1'b0;
      fixed   <= 1'b0;
      left    <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      cap_q <= rd_q;
      if (cap_q) txbuf <= bus_rdata;
      if (wr_q) addr <= addr + 16'd1;
      if (cs_hi) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        hi_done <= 1'b0;
        tx_sh   <= '0;
      end else begin
        if (rise) begin
          sh_in   <= byte_in;
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (fall)
          tx_sh <= bit_cnt != 3'd0 ? {tx_sh[DW-2:0], 1'b0} :
                   (phase == PH_DATA && !is_wr) ? txbuf : '0;
        if (last_bit)
          case (phase)
            PH_ADDR:
              if (!hi_done) begin
                addr[15:8] <= byte_in;
                hi_done    <= 1'b1;
              end else begin
                addr[7:0] <= byte_in;
                phase     <= PH_CTRL;
              end
            PH_CTRL: begin
              blk   <= byte_in[7:3];
              is_wr <= byte_in[2];
              fixed <= |byte_in[1:0];
              left  <= len;
              rd_q  <= !byte_in[2];
              phase <= PH_DATA;
            end
            PH_DATA: begin
              if (fixed) left <= left - 3'd1;
              if (!more) phase <= PH_DONE;
              if (is_wr) begin
                wr_q    <= 1'b1;
                wdata_q <= byte_in;
              end else begin
                addr <= addr + 16'd1;
                rd_q <= more;
              end
            end
            default: ;
          endcase
      end
    end

  assign spi_miso  = tx_sh[DW-1];
  assign bus_addr  = addr;
  assign bus_blk   = blk;
  assign bus_wr    = wr_q;
  assign bus_rd    = rd_q;
  assign bus_wdata = wdata_q;

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R10
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr); // R3
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_hi) |-> !bus_wr && !bus_rd && !spi_miso); // R1
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && $past(phase == PH_DONE)) |-> !bus_wr && !bus_rd); // R5
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    left <= 3'd4); // R5
endmodule

// File: tb/test_spi_frame_slave.sv
module test_spi_frame_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [4:0]  bus_blk;
  logic [7:0]  bus_wdata, bus_rdata = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  spi_frame_slave i_spi_frame_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_addr(bus_addr),
    .bus_blk(bus_blk), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata));

  int checks = 0, errors = 0, wn = 0, rn = 0, both = 0;
  bit finished = 1'b0;
  logic [15:0] wa[16], ra[16];
  logic [4:0]  wb[16];
  logic [7:0]  wd[16], wdat[8], rxd[8];

  function automatic logic [7:0] model(input logic [4:0] b, input logic [15:0] a);
    return (a[7:0] ^ a[15:8]) + {b, 3'b011};
  endfunction

  always @(posedge clk) begin
    if (bus_rd) bus_rdata <= model(bus_blk, bus_addr);
    if (bus_wr) begin
      if (wn < 16) begin wa[wn] = bus_addr; wb[wn] = bus_blk; wd[wn] = bus_wdata; end
      wn++;
    end
    if (bus_rd) begin
      if (rn < 16) ra[rn] = bus_addr;
      rn++;
    end
    if (bus_wr && bus_rd) both++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tx[i];
      wait_clk(HALF);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [15:0] a, input logic [7:0] ctrl,
                       input int n, input int tail);
    logic [7:0] junk;
    wn = 0; rn = 0;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    xfer(a[15:8], 8, junk);
    xfer(a[7:0], 8, junk);
    xfer(ctrl, 8, junk);
    for (int k = 0; k < n; k++) xfer(wdat[k], 8, rxd[k]);
    if (tail > 0) xfer(8'hFF, tail, junk);
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    chk(!bus_wr && !bus_rd, "R1", "strobes after reset", {bus_wr, bus_rd}, 0);
    chk(spi_miso == 1'b0, "R1", "miso after reset", spi_miso, 0);

    for (int mode = 0; mode < 4; mode++)
      for (int dir = 0; dir < 2; dir++)
        for (int n = 1; n <= 5; n++) begin
          int L, ew, er;
          logic [15:0] a;
          logic [4:0] b;
          L  = mode == 0 ? 0 : mode == 1 ? 1 : mode == 2 ? 2 : 4;
          a  = (n == 5) ? 16'hFFFE : 16'(16'h1000 * mode + 16'h0101 * n + 16'h0040 * dir);
          b  = 5'((mode * 7 + n * 3 + dir * 11) % 32);
          for (int k = 0; k < 8; k++) wdat[k] = 8'(8'hA5 ^ (k * 37 + n * 5 + mode));
          frame(a, {b, dir[0], mode[1:0]}, n, 0);
          ew = dir == 0 ? 0 : (L == 0 ? n : (n < L ? n : L));
          er = dir == 1 ? 0 : (L == 0 ? n + 1 : (n < L ? n + 1 : L));
          chk(wn == ew, L == 0 ? "R6" : "R5", "write strobe count", wn, ew);
          chk(rn == er, L == 0 ? "R6" : "R5", "read strobe count", rn, er);
          for (int k = 0; k < ew && k < wn; k++) begin
            chk(wa[k] == 16'(a + k), k == 0 ? "R2" : "R4", "write offset", wa[k], 16'(a + k));
            chk(wb[k] == b, "R2", "write block", wb[k], b);
            chk(wd[k] == wdat[k], "R3", "write data", wd[k], wdat[k]);
          end
          for (int k = 0; k < er && k < rn; k++)
            chk(ra[k] == 16'(a + k), k == 0 ? "R2" : "R4", "read offset", ra[k], 16'(a + k));
          if (dir == 0)
            for (int k = 0; k < n; k++) begin
              logic [7:0] e;
              e = (L == 0 || k < L) ? model(b, 16'(a + k)) : 8'h00;
              chk(rxd[k] == e, (L != 0 && k >= L) ? "R5" : "R7", "miso byte", rxd[k], e);
            end
          chk(spi_miso == 1'b0, "R1", "miso idle after frame", spi_miso, 0);
        end

    wdat[0] = 8'h5A;
    frame(16'h2222, {5'd3, 1'b1, 2'b11}, 1, 5);
    chk(wn == 1, "R8", "writes with torn data byte", wn, 1);
    chk(wd[0] == 8'h5A, "R3", "whole byte before abort", wd[0], 8'h5A);

    frame(16'h3333, {5'd4, 1'b0, 2'b00}, 0, 3);
    chk(rn == 1, "R8", "reads with torn read byte", rn, 1);
    chk(wn == 0, "R8", "no write on torn read", wn, 0);

    begin
      logic [7:0] junk;
      wn = 0; rn = 0;
      spi_cs_n = 1'b0;
      wait_clk(HALF);
      xfer(8'h12, 8, junk);
      xfer(8'h34, 4, junk);
      wait_clk(HALF);
      spi_cs_n = 1'b1;
      wait_clk(20);
      chk(wn == 0 && rn == 0, "R8", "strobes after torn offset", wn + rn, 0);
    end

    wdat[0] = 8'h3C;
    frame(16'h0BCD, {5'd9, 1'b1, 2'b01}, 1, 0);
    chk(wn == 1, "R9", "fresh frame write count", wn, 1);
    chk(wa[0] == 16'h0BCD, "R9", "fresh frame offset", wa[0], 16'h0BCD);
    chk(wb[0] == 5'd9, "R9", "fresh frame block", wb[0], 9);
    chk(wd[0] == 8'h3C, "R9", "fresh frame data", wd[0], 8'h3C);

    chk(both == 0, "R10", "write and read together", both, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule